// File: doc/BRIEF.md
# Buffered Serial Transmitter with Selectable Frame Format

This block turns bytes into asynchronous serial frames on a single output line. Software writes a byte into a one-entry holding buffer. At the next bit boundary, marked by a one-cycle `bit_tick` pulse from an external rate generator, the byte moves into a shift register and goes out on `txd`, one bit per tick interval. Because the buffer and the shifter are separate, the next byte can be written while the current frame is still on the line. The two frames then follow each other with no idle bit between them.

Four controls set the frame shape: character length (7 or 8 bits), parity on or off, parity sense, and the number of stop bits. The controls are sampled when a byte enters the shifter. Two flags report progress. `buf_empty` shows that the holding buffer can take a byte. `shift_done` shows that the line has gone idle after the last stop bit. A source select chooses which of the two events raises the one-cycle `tx_irq` pulse. Dropping `tx_en` aborts any frame in progress, discards any buffered byte and returns the transmitter to its idle state.

Top module: `uart_tx_buffered`

## Requirements
- R1: While the transmitter is idle, `txd` is 1. After reset, `txd`=1, `buf_empty`=1, `shift_done`=1 and `tx_irq`=0.
- R2: A `wr_stb` with `tx_en`=1 and `buf_empty`=1 stores `wr_data`, and `buf_empty` reads 0 from the next cycle on. A strobe is ignored while the buffer is full or while `tx_en`=0, and the ignored byte never appears on `txd`.
- R3: When a `bit_tick` arrives, the buffer is full and the shifter is idle, the byte moves to the shifter on that edge. On the same edge `buf_empty` becomes 1, `shift_done` becomes 0 and `txd` drives the start bit.
- R4: A frame on `txd` is, in this order: one start bit of 0, the data bits with bit 0 first, the parity bit if enabled, then the stop bits of 1. Each bit holds for one tick interval and the next bit appears on the edge of the following tick.
- R5: With `fmt_seven`=0, eight data bits `wr_data[7:0]` are sent. With `fmt_seven`=1, seven bits `wr_data[6:0]` are sent and bit 7 is never sent.
- R6: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the number of ones in data plus parity is even; with `par_odd`=1 it is odd. With `par_en`=0, no parity bit is sent.
- R7: With `two_stop`=0 the frame ends with one stop bit; with `two_stop`=1 it ends with two.
- R8: The format controls are sampled when the byte enters the shifter. Changing them during a frame does not alter that frame.
- R9: At the tick that ends the last stop bit, if the buffer is empty, `shift_done` becomes 1 and `txd` stays 1. If the buffer is full, the next frame's start bit begins on that same tick and `shift_done` stays 0.
- R10: `tx_irq` is a one-cycle pulse. With `irq_on_done`=0 it fires on the edge where a transfer empties the buffer. With `irq_on_done`=1 it fires on the edge where `shift_done` rises at the end of a frame.
- R11: While `tx_en`=0, the next edge forces `txd`=1, `buf_empty`=1, `shift_done`=1 and `tx_irq`=0. The frame in progress and any buffered byte are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; 0 holds the transmitter in its initial state |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WORD_W | Byte to transmit |
| fmt_seven | input | 1 | 0: 8-bit characters, 1: 7-bit characters |
| par_en | input | 1 | 1: append a parity bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| irq_on_done | input | 1 | Interrupt source: 0 buffer emptied, 1 shift complete |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| shift_done | output | 1 | Shifter idle after the last stop bit |
| tx_irq | output | 1 | One-cycle transmit interrupt request |

## Verification
Every result is one register stage from its cause. `buf_empty` falls one cycle after the write strobe. The start bit, the rise of `buf_empty` and the buffer-empty interrupt all appear one cycle after the tick that moves the byte. Each later bit appears one cycle after its own tick, and `shift_done` with the completion interrupt appears one cycle after the tick that follows the frame's last bit. The bench drives every strobe and tick on a falling edge and samples on the next falling edge, exactly one register stage later, so each comparison lands in the cycle where the value first becomes due. A frame of N bits is read as the N samples taken after ticks 1 to N, and tick N+1 is checked for completion or for the next start bit.

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fmt_seven,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              irq_on_done,
  input  logic              bit_tick,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_done,
  output logic              tx_irq
);

  localparam int FRAME_W = WORD_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [WORD_W-1:0]  hold_q;
  logic               hold_full_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic               done_q;
  logic               irq_q;

  logic [WORD_W-1:0]  data_m;
  logic [CNT_W-1:0]   char_len;
  logic               par_bit;
  logic [FRAME_W-1:0] next_frame;
  logic [CNT_W-1:0]   next_len;
  logic               last_bit;
  logic               take;

  assign data_m   = fmt_seven ? {1'b0, hold_q[WORD_W-2:0]} : hold_q;
  assign char_len = fmt_seven ? CNT_W'(WORD_W - 1) : CNT_W'(WORD_W);
  assign par_bit  = (^data_m) ^ par_odd;

  assign next_frame = ({FRAME_W{1'b1}} << (char_len + CNT_W'(1) + CNT_W'(par_en)))
                    | (FRAME_W'(par_en & par_bit) << (char_len + CNT_W'(1)))
                    | (FRAME_W'(data_m) << 1);
  assign next_len   = char_len + CNT_W'(2) + CNT_W'(par_en) + CNT_W'(two_stop);

  assign last_bit = busy_q && (left_q == CNT_W'(1));
  assign take     = bit_tick && hold_full_q && (!busy_q || last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shreg_q     <= '1;
      left_q      <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b1;
      irq_q       <= 1'b0;
    end else if (!tx_en) begin
      hold_full_q <= 1'b0;
      shreg_q     <= '1;
      left_q      <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b1;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_stb && !hold_full_q) begin
        hold_q      <= wr_data;
        hold_full_q <= 1'b1;
      end
      if (take) begin
        shreg_q     <= next_frame;
        left_q      <= next_len;
        busy_q      <= 1'b1;
        hold_full_q <= 1'b0;
        done_q      <= 1'b0;
        irq_q       <= !irq_on_done;
      end else if (bit_tick && last_bit) begin
        shreg_q <= '1;
        left_q  <= '0;
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        irq_q   <= irq_on_done;
      end else if (bit_tick && busy_q) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - CNT_W'(1);
      end
    end
  end

  assign txd        = shreg_q[0];
  assign buf_empty  = !hold_full_q;
  assign shift_done = done_q;
  assign tx_irq     = irq_q;

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_empty && tx_en && !bit_tick) |=> !buf_empty); // R2

  AST_START_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && $rose(buf_empty)) |-> ($past(bit_tick) && !txd && !shift_done)); // R3

  AST_STOP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && $rose(shift_done)) |-> (txd && $past(txd))); // R9

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> ($past(irq_on_done) ? $rose(shift_done) : $rose(buf_empty))); // R10

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && buf_empty && shift_done && !tx_irq)); // R11

endmodule

// File: tb/uart_tx_buffered_tb.sv
module uart_tx_buffered_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fmt_seven = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       irq_on_done = 1'b0;
  logic       bit_tick = 1'b0;
  logic       txd, buf_empty, shift_done, tx_irq;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_buffered #(.WORD_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .fmt_seven(fmt_seven), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .irq_on_done(irq_on_done), .bit_tick(bit_tick),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic set_fmt(input bit s, input bit pe, input bit po, input bit ts, input bit sel);
    fmt_seven = s; par_en = pe; par_odd = po; two_stop = ts; irq_on_done = sel;
  endtask

  function automatic void exp_frame(input logic [7:0] d, input bit s, input bit pe,
                                    input bit po, input bit ts,
                                    output logic [15:0] e, output int n);
    logic [7:0] dm;
    int pos;
    dm  = s ? {1'b0, d[6:0]} : d;
    e   = 16'(dm) << 1;
    pos = (s ? 7 : 8) + 1;
    if (pe) begin
      e[pos] = 1'((($countones(dm) % 2) == 1)) ^ po;
      pos++;
    end
    e[pos] = 1'b1; pos++;
    if (ts) begin e[pos] = 1'b1; pos++; end
    n = pos;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!ended) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] e, cap, e2;
    int n, n2;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset buf_empty", buf_empty, 1);
    chk("R1 reset shift_done", shift_done, 1);
    chk("R1 reset tx_irq", tx_irq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle txd", txd, 1);

    // R4 R5 R6 R7 R10: sweep every format with several data patterns
    for (int f = 0; f < 16; f++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] d;
        d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 73 + f * 29 + 5);
        set_fmt(f[0], f[1], f[2], f[3], i[0]);
        exp_frame(d, f[0], f[1], f[2], f[3], e, n);
        do_write(d);
        chk("R2 buffer fills", buf_empty, 0);
        cap = '0;
        for (int k = 1; k <= n; k++) begin
          do_tick();
          cap[k-1] = txd;
          if (k == 1) begin
            chk("R3 buffer empties on move", buf_empty, 1);
            chk("R3 shift_done clears", shift_done, 0);
            chk("R10 irq on buffer empty", tx_irq, !irq_on_done);
          end
        end
        chk("R4 R5 R6 R7 frame bits", cap, e);
        do_tick();
        chk("R9 shift_done after stop", shift_done, 1);
        chk("R9 line idle after stop", txd, 1);
        chk("R10 irq on shift done", tx_irq, irq_on_done);
        @(negedge clk);
        chk("R10 irq one cycle", tx_irq, 0);
      end
    end

    // R2: write while full is ignored
    set_fmt(0, 0, 0, 0, 0);
    exp_frame(8'h11, 0, 0, 0, 0, e, n);
    do_write(8'h11);
    do_write(8'h22);
    cap = '0;
    for (int k = 1; k <= n; k++) begin do_tick(); cap[k-1] = txd; end
    chk("R2 first byte kept", cap, e);
    do_tick();
    chk("R2 no second frame done", shift_done, 1);
    for (int k = 0; k < 4; k++) begin
      do_tick();
      chk("R2 ignored byte not sent", txd, 1);
    end
    chk("R2 buffer stays empty", buf_empty, 1);

    // R9: back-to-back frames without an idle bit
    set_fmt(1, 1, 1, 0, 1);
    exp_frame(8'h3C, 1, 1, 1, 0, e, n);
    exp_frame(8'hC3, 1, 1, 1, 0, e2, n2);
    do_write(8'h3C);
    do_tick();
    cap = '0; cap[0] = txd;
    do_write(8'hC3);
    chk("R2 second byte accepted while shifting", buf_empty, 0);
    for (int k = 2; k <= n; k++) begin do_tick(); cap[k-1] = txd; end
    chk("R9 first frame bits", cap, e);
    do_tick();
    chk("R9 next start bit at once", txd, 0);
    chk("R9 shift_done held low", shift_done, 0);
    chk("R9 buffer emptied by reload", buf_empty, 1);
    chk("R10 no done irq on reload", tx_irq, 0);
    cap = '0; cap[0] = txd;
    for (int k = 2; k <= n2; k++) begin do_tick(); cap[k-1] = txd; end
    chk("R9 second frame bits", cap, e2);
    do_tick();
    chk("R9 done after second frame", shift_done, 1);
    chk("R10 done irq after second frame", tx_irq, 1);

    // R8: format sampled when the byte enters the shifter
    set_fmt(0, 1, 0, 1, 0);
    exp_frame(8'h96, 0, 1, 0, 1, e, n);
    do_write(8'h96);
    do_tick();
    cap = '0; cap[0] = txd;
    set_fmt(1, 0, 1, 0, 1);
    for (int k = 2; k <= n; k++) begin do_tick(); cap[k-1] = txd; end
    chk("R8 frame keeps loaded format", cap, e);
    do_tick();
    chk("R8 done after full frame", shift_done, 1);

    // R11: disable aborts the frame and drops the buffer
    set_fmt(0, 0, 0, 0, 0);
    do_write(8'h00);
    do_tick();
    do_tick();
    do_write(8'hAA);
    chk("R11 line low mid frame", txd, 0);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    chk("R11 txd forced high", txd, 1);
    chk("R11 buffer cleared", buf_empty, 1);
    chk("R11 shift_done set", shift_done, 1);
    chk("R11 no irq", tx_irq, 0);
    do_write(8'h0F);
    chk("R2 write while disabled ignored", buf_empty, 1);
    @(negedge clk); tx_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      do_tick();
      chk("R11 nothing sent after enable", txd, 1);
    end
    chk("R11 buffer still empty", buf_empty, 1);
    exp_frame(8'h5B, 0, 0, 0, 0, e, n);
    do_write(8'h5B);
    cap = '0;
    for (int k = 1; k <= n; k++) begin do_tick(); cap[k-1] = txd; end
    chk("R11 frame after re-enable", cap, e);
    do_tick();
    chk("R11 done after re-enable", shift_done, 1);

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule